// File: doc/BRIEF.md
# Security-Gated Performance Counter Bank

This block holds a bank of event counters and one cycle counter, together with the logic that decides, in every clock, whether each counter may step. Software-level enables and per-event pulses request increments. A set of secure-side control bits, the current security state and privilege level, a prohibit-select input for the cycle counter and an external non-invasive debug permission then allow or veto each increment. Every counter wraps to zero and sets a sticky overflow flag when it does. A synchronous clear input empties the whole bank.

The bank also produces the effective multithread select of each event counter. A master multithread enable can force these selects to zero. Whether the highest privilege level exists is a build-time parameter. When it is absent, the non-secure indicator input decides whether the secure event-enable control is treated as set.

Top module: `pcg_top`

## Requirements
- R1: Event counter i increments by one at a clock edge where its event pulse and its enable are both 1 and event counting is permitted. Otherwise it holds. Counter i occupies bits [i*EVT_W +: EVT_W] of the flat count output.
- R2: The cycle counter increments by one at every clock edge where its enable is 1 and cycle counting is permitted. Otherwise it holds.
- R3: While the secure cycle-disable control is 1 and the processor is in Secure state or at the top privilege level, the cycle counter holds. This control never stops an event counter.
- R4: While the effective secure event-enable is 0, every event counter holds in Secure state. In non-secure state the event counters are not affected by it.
- R5: In Secure state with the effective secure event-enable at 0, the cycle counter holds when the prohibit-select input is 1. When that input is 0, the cycle counter ignores the secure event-enable.
- R6: While the external non-invasive debug permission is 1, the secure event-enable control has no effect on any counter.
- R7: When built without the top privilege level, a non-secure indicator of 0 makes the secure event-enable behave as 1. When built with the top level, the non-secure indicator has no effect.
- R8: While the multithread enable is 0, every effective multithread select output is 0. While it is 1, each output equals its select input.
- R9: A counter that steps from its all-ones value to zero sets its overflow flag. The flag stays at 1 through later counting until a clear.
- R10: A clear input of 1 at a clock edge zeroes all counts and all overflow flags at that edge, and it takes precedence over any increment.
- R11: After reset, all counts and overflow flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of counts and flags |
| is_secure | input | 1 | Processor is in Secure state |
| at_top | input | 1 | Processor is at the top privilege level |
| ns_bit | input | 1 | Non-secure indicator (used only when the top level is absent) |
| cyc_sec_dis | input | 1 | Secure cycle-counter disable control |
| sec_evt_en | input | 1 | Secure event-counting enable control |
| mt_en | input | 1 | Master multithread enable control |
| ext_nidbg | input | 1 | External non-invasive debug permission |
| dp | input | 1 | Cycle-counter prohibit select |
| cyc_en | input | 1 | Cycle counter enable |
| evt_en | input | N_EVT | Per-event-counter enables |
| evt_pulse | input | N_EVT | Per-counter event pulses |
| mt_sel | input | N_EVT | Per-counter multithread select requests |
| mt_eff | output | N_EVT | Effective multithread selects |
| evt_cnt | output | N_EVT*EVT_W | Event counts, flat |
| evt_ovf | output | N_EVT | Event overflow flags |
| cyc_cnt | output | CYC_W | Cycle count |
| cyc_ovf | output | 1 | Cycle overflow flag |

## Verification
The bench builds two instances with four event counters. Event counters are 6 bits wide and the cycle counter is 8 bits wide, so both wrap in the first few hundred cycles. That makes the overflow flag and its stickiness reachable, which the default widths of 32 and 64 bits would not allow. One instance keeps the top privilege level and the other is built without it. Both see the same inputs, so the single case where the non-secure indicator matters can be compared between them.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

   // Per-cycle counting permission produced by the gating logic
   typedef struct packed {
      logic evt_ok;
      logic cyc_ok;
   } pcg_permit_t;

endpackage

// File: rtl/pcg_permit.sv
module pcg_permit
   import pcg_pkg::*;
#(
   parameter int TOP_PRESENT = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        is_secure,
   input  logic        at_top,
   input  logic        ns_bit,
   input  logic        cyc_sec_dis,
   input  logic        sec_evt_en,
   input  logic        ext_nidbg,
   input  logic        dp,
   output pcg_permit_t permit
);

   localparam logic TOP_ABSENT = (TOP_PRESENT == 0);

   logic sec_en_eff;
   logic sec_block;
   logic cyc_sec_block;

   // Effective secure enable: external permission or missing top level lift it
   assign sec_en_eff    = sec_evt_en | ext_nidbg | (TOP_ABSENT & ~ns_bit);
   assign sec_block     = is_secure & ~sec_en_eff;
   assign cyc_sec_block = cyc_sec_dis & (is_secure | at_top);

   assign permit.evt_ok = ~sec_block;
   assign permit.cyc_ok = ~cyc_sec_block & ~(dp & sec_block);

   // R6: the external permission always lets event counting through
   assert_nidbg_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ext_nidbg |-> permit.evt_ok);

   // R4: outside Secure state event counting is never vetoed
   assert_nonsec_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !is_secure |-> permit.evt_ok);

endmodule

// File: rtl/pcg_counter.sv
module pcg_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt,
   output logic         ovf
);

   localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

   if (W < 2) begin : g_bad_width
      $error("pcg_counter: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         ovf <= 1'b0;
      end else if (clr) begin
         cnt <= '0;
         ovf <= 1'b0;
      end else if (inc) begin
         cnt <= cnt + 1'b1;
         if (cnt == ALL_ONES) ovf <= 1'b1;
      end
   end

   // R1/R2: a permitted request advances the count by exactly one
   assert_inc_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && inc) |=> cnt == $past(cnt) + 1'b1);

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !inc) |=> cnt == $past(cnt));

   assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && inc && cnt == ALL_ONES) |=> (ovf && cnt == '0));

   assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && ovf) |=> ovf);

   assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0 && !ovf));

endmodule

// File: rtl/pcg_top.sv
module pcg_top
   import pcg_pkg::*;
#(
   parameter int N_EVT       = 4,
   parameter int EVT_W       = 32,
   parameter int CYC_W       = 64,
   parameter int TOP_PRESENT = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   is_secure,
   input  logic                   at_top,
   input  logic                   ns_bit,
   input  logic                   cyc_sec_dis,
   input  logic                   sec_evt_en,
   input  logic                   mt_en,
   input  logic                   ext_nidbg,
   input  logic                   dp,
   input  logic                   cyc_en,
   input  logic [N_EVT-1:0]       evt_en,
   input  logic [N_EVT-1:0]       evt_pulse,
   input  logic [N_EVT-1:0]       mt_sel,
   output logic [N_EVT-1:0]       mt_eff,
   output logic [N_EVT*EVT_W-1:0] evt_cnt,
   output logic [N_EVT-1:0]       evt_ovf,
   output logic [CYC_W-1:0]       cyc_cnt,
   output logic                   cyc_ovf
);

   localparam int CNT_BITS = N_EVT * EVT_W;

   if (N_EVT < 1 || N_EVT > 31) begin : g_bad_count
      $error("pcg_top: N_EVT must lie in 1..31");
   end
   if (TOP_PRESENT != 0 && TOP_PRESENT != 1) begin : g_bad_top
      $error("pcg_top: TOP_PRESENT must be 0 or 1");
   end
   if (CNT_BITS > 4096) begin : g_bad_bits
      $error("pcg_top: counter bank too wide");
   end

   pcg_permit_t permit;

   pcg_permit #(.TOP_PRESENT(TOP_PRESENT)) permit_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .is_secure   (is_secure),
      .at_top      (at_top),
      .ns_bit      (ns_bit),
      .cyc_sec_dis (cyc_sec_dis),
      .sec_evt_en  (sec_evt_en),
      .ext_nidbg   (ext_nidbg),
      .dp          (dp),
      .permit      (permit)
   );

   for (genvar i = 0; i < N_EVT; i++) begin : g_evt
      logic inc_i;
      assign inc_i     = evt_pulse[i] & evt_en[i] & permit.evt_ok;
      assign mt_eff[i] = mt_sel[i] & mt_en;

      pcg_counter #(.W(EVT_W)) ctr_i (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (clr),
         .inc   (inc_i),
         .cnt   (evt_cnt[i*EVT_W +: EVT_W]),
         .ovf   (evt_ovf[i])
      );
   end

   pcg_counter #(.W(CYC_W)) cyc_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .inc   (cyc_en & permit.cyc_ok),
      .cnt   (cyc_cnt),
      .ovf   (cyc_ovf)
   );

   // R3: secure cycle disable freezes the cycle counter in Secure state or at the top level
   assert_sccd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && cyc_sec_dis && (is_secure || at_top)) |=> cyc_cnt == $past(cyc_cnt));

   // R4/R7: without any lift of the secure enable, Secure state freezes the event bank
   assert_secevt_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && is_secure && !sec_evt_en && !ext_nidbg && (TOP_PRESENT != 0 || ns_bit))
      |=> evt_cnt == $past(evt_cnt));

   // R5: with prohibit select set, the same condition also freezes the cycle counter
   assert_dp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && dp && is_secure && !sec_evt_en && !ext_nidbg && (TOP_PRESENT != 0 || ns_bit))
      |=> cyc_cnt == $past(cyc_cnt));

   // R8: multithread selects are masked by the master enable
   assert_mt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !mt_en |-> mt_eff == '0);

endmodule

// File: tb/pcg_top_tb_top.sv
module pcg_top_tb_top;

   localparam int N  = 4;
   localparam int EW = 6;
   localparam int CW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr = 1'b0;
   logic is_secure = 1'b0, at_top = 1'b0, ns_bit = 1'b0;
   logic cyc_sec_dis = 1'b0, sec_evt_en = 1'b0, mt_en = 1'b0;
   logic ext_nidbg = 1'b0, dp = 1'b0, cyc_en = 1'b0;
   logic [N-1:0] evt_en = '0, evt_pulse = '0, mt_sel = '0;

   logic [N-1:0]    mt_eff, mt_eff_nl;
   logic [N*EW-1:0] evt_cnt, evt_cnt_nl;
   logic [N-1:0]    evt_ovf, evt_ovf_nl;
   logic [CW-1:0]   cyc_cnt, cyc_cnt_nl;
   logic            cyc_ovf, cyc_ovf_nl;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   pcg_top #(.N_EVT(N), .EVT_W(EW), .CYC_W(CW), .TOP_PRESENT(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .is_secure(is_secure), .at_top(at_top),
      .ns_bit(ns_bit), .cyc_sec_dis(cyc_sec_dis), .sec_evt_en(sec_evt_en),
      .mt_en(mt_en), .ext_nidbg(ext_nidbg), .dp(dp), .cyc_en(cyc_en),
      .evt_en(evt_en), .evt_pulse(evt_pulse), .mt_sel(mt_sel), .mt_eff(mt_eff),
      .evt_cnt(evt_cnt), .evt_ovf(evt_ovf), .cyc_cnt(cyc_cnt), .cyc_ovf(cyc_ovf)
   );

   pcg_top #(.N_EVT(N), .EVT_W(EW), .CYC_W(CW), .TOP_PRESENT(0)) dut_nl_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .is_secure(is_secure), .at_top(at_top),
      .ns_bit(ns_bit), .cyc_sec_dis(cyc_sec_dis), .sec_evt_en(sec_evt_en),
      .mt_en(mt_en), .ext_nidbg(ext_nidbg), .dp(dp), .cyc_en(cyc_en),
      .evt_en(evt_en), .evt_pulse(evt_pulse), .mt_sel(mt_sel), .mt_eff(mt_eff_nl),
      .evt_cnt(evt_cnt_nl), .evt_ovf(evt_ovf_nl), .cyc_cnt(cyc_cnt_nl), .cyc_ovf(cyc_ovf_nl)
   );

   // Vector: [8]secure [7]top [6]ns [5]cyc_dis [4]sec_en [3]nidbg [2]dp [1]exp_evt [0]exp_cyc
   localparam int NV = 10;
   localparam logic [8:0] VEC [NV] = '{
      9'b0_0_0_0_0_0_0_1_1,   // non-secure, nothing vetoed (R4)
      9'b1_0_0_0_0_0_0_0_1,   // secure, enable off, dp 0: cycles run (R5)
      9'b1_0_0_0_0_0_1_0_0,   // secure, enable off, dp 1: both stop (R5)
      9'b1_0_0_0_1_0_1_1_1,   // secure, enable on (R4)
      9'b1_0_0_1_1_0_0_1_0,   // cycle disable in secure, events run (R3)
      9'b0_1_0_1_0_0_0_1_0,   // cycle disable at top level (R3)
      9'b0_0_0_1_0_0_1_1_1,   // cycle disable non-secure below top (R3)
      9'b1_0_0_0_0_1_1_1_1,   // external permission lifts veto (R6)
      9'b1_0_0_1_0_1_0_1_0,   // external permission does not lift cycle disable (R6)
      9'b1_0_0_0_0_0_1_0_0    // ns 0 with top present changes nothing (R7)
   };

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic do_clear();
      clr = 1'b1;
      tick(1);
      clr = 1'b0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      tick(3);
      // R11: reset state
      check("R11 evt_cnt after reset", 64'(evt_cnt), 64'd0);
      check("R11 flags after reset", {59'd0, cyc_ovf, evt_ovf}, 64'd0);
      check("R11 cyc_cnt after reset", 64'(cyc_cnt), 64'd0);
      rst_n = 1'b1;
      tick(1);

      // Table walk: gating under each control pattern, three requests per entry
      for (int v = 0; v < NV; v++) begin
         do_clear();
         {is_secure, at_top, ns_bit, cyc_sec_dis, sec_evt_en, ext_nidbg, dp} = VEC[v][8:2];
         evt_pulse = '1; evt_en = '1; cyc_en = 1'b1;
         tick(3);
         evt_pulse = '0; evt_en = '0; cyc_en = 1'b0;
         for (int i = 0; i < N; i++)
            check($sformatf("R1/R3/R4/R6/R7 vector %0d evt %0d", v, i),
                  64'(evt_cnt[i*EW +: EW]), VEC[v][1] ? 64'd3 : 64'd0);
         check($sformatf("R2/R3/R5/R6 vector %0d cycle", v),
               64'(cyc_cnt), VEC[v][0] ? 64'd3 : 64'd0);
      end

      // R7: without the top level, ns 0 lifts the veto; ns 1 does not
      do_clear();
      {is_secure, at_top, cyc_sec_dis, sec_evt_en, ext_nidbg, dp} = 6'b100001;
      ns_bit = 1'b0;
      evt_pulse = '1; evt_en = '1; cyc_en = 1'b1;
      tick(2);
      check("R7 no-top ns0 evt0", 64'(evt_cnt_nl[0 +: EW]), 64'd2);
      check("R7 no-top ns0 cycle", 64'(cyc_cnt_nl), 64'd2);
      check("R7 top ns0 evt0", 64'(evt_cnt[0 +: EW]), 64'd0);
      ns_bit = 1'b1;
      tick(2);
      check("R7 no-top ns1 evt0", 64'(evt_cnt_nl[0 +: EW]), 64'd2);
      check("R7 no-top ns1 cycle", 64'(cyc_cnt_nl), 64'd2);
      evt_pulse = '0; evt_en = '0; cyc_en = 1'b0;
      {is_secure, ns_bit, dp} = 3'b000;

      // R1/R2: per-counter pattern with cycle enable off
      do_clear();
      evt_pulse = 4'b0101; evt_en = 4'b0111;
      tick(2);
      evt_pulse = '0; evt_en = '0;
      check("R1 pattern counts", 64'(evt_cnt), 64'({6'd0, 6'd2, 6'd0, 6'd2}));
      check("R2 cycle held with enable off", 64'(cyc_cnt), 64'd0);

      // R8: multithread masking
      mt_sel = 4'b1011; mt_en = 1'b0;
      tick(1);
      check("R8 mask off", 64'(mt_eff), 64'd0);
      mt_en = 1'b1;
      tick(1);
      check("R8 pass through", 64'(mt_eff), 64'hB);

      // R9: event counter 0 wraps after 2^EW events; flag stays
      do_clear();
      evt_pulse = 4'b0001; evt_en = 4'b0001;
      tick(1 << EW);
      check("R9 evt0 wrapped to zero", 64'(evt_cnt[0 +: EW]), 64'd0);
      check("R9 evt flags after wrap", 64'(evt_ovf), 64'd1);
      tick(1);
      check("R9 evt flag sticky", 64'(evt_ovf), 64'd1);
      check("R9 evt0 counts on", 64'(evt_cnt[0 +: EW]), 64'd1);
      evt_pulse = '0; evt_en = '0;

      // R9: cycle counter wrap
      cyc_en = 1'b1;
      tick((1 << CW) - 1);
      check("R9 cycle flag not yet set", 64'(cyc_ovf), 64'd0);
      tick(1);
      check("R9 cycle wrapped", {55'd0, cyc_ovf, cyc_cnt}, {55'd0, 1'b1, 8'd0});
      tick(1);
      check("R9 cycle flag sticky", 64'(cyc_ovf), 64'd1);

      // R10: clear wins over concurrent increments
      evt_pulse = '1; evt_en = '1;
      clr = 1'b1;
      tick(1);
      clr = 1'b0; evt_pulse = '0; evt_en = '0; cyc_en = 1'b0;
      check("R10 counts cleared", 64'(evt_cnt), 64'd0);
      check("R10 cycle cleared", 64'(cyc_cnt), 64'd0);
      check("R10 flags cleared", {59'd0, cyc_ovf, evt_ovf}, 64'd0);

      finish_run();
   end

endmodule